// File: doc/BRIEF.md
# Single-Port Synchronous Memory with Access Acknowledge

This block is a word-addressed storage array with one shared port. An access starts when the access enable `acc_en` is sampled high on a rising clock edge. The write select `wr_sel` then picks between two actions. A write stores a word. A read loads a word into a registered output.

`done` acknowledges every enabled access one cycle later, including accesses that fail. A write always marks the registered read output as stale. Each access also reports whether its address and write data were usable. The requester supplies `addr_ok` and `wdata_ok` to say whether those values are defined. An address at or beyond the number of stored words counts as undefined. A failed access raises a one-cycle error pulse and leaves the stored words as they were.

The block suits a controller that issues one access at a time and waits for `done`. Error pulses can be collected by a diagnostic monitor outside the block.

Top module: `seqmem_ack`

## Requirements
- R1: A write (`acc_en`=1, `wr_sel`=1) with `addr_ok`=1, `addr` < SIZE and `wdata_ok`=1 stores `wdata` at `addr`. A later read of that address returns the stored word.
- R2: A read (`acc_en`=1, `wr_sel`=0) with a defined address puts the word at `addr` on `rdata` and sets `rdata_vld` to 1. Both appear in the cycle after the sampling edge.
- R3: Any write, whether or not it stores, clears `rdata_vld` in the following cycle.
- R4: `done` is 1 in the cycle after each edge where `acc_en` is sampled 1. This includes accesses that raise an error. `done` is 0 in the cycle after an edge where `acc_en` is sampled 0.
- R5: While `acc_en` is 0, `rdata` and `rdata_vld` keep their values.
- R6: A write whose address is undefined (`addr_ok`=0, or `addr` >= SIZE) pulses `err_waddr` for one cycle and leaves all stored words unchanged.
- R7: A write with `wdata_ok`=0 pulses `err_wdata` for one cycle and leaves all stored words unchanged. This pulse is independent of `err_waddr`.
- R8: A read whose address is undefined pulses `err_raddr` for one cycle and clears `rdata_vld`.
- R9: While `rst_n` is 0, `done`, the three error flags and `rdata_vld` are 0, and no access is performed, even with `acc_en` high. Stored words survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_en | input | 1 | Starts an access on this edge |
| wr_sel | input | 1 | 1 selects write, 0 selects read |
| addr | input | AW = clog2(SIZE) | Word address |
| addr_ok | input | 1 | Address is defined |
| wdata | input | WIDTH | Write word |
| wdata_ok | input | 1 | Write word is defined |
| rdata | output | WIDTH | Registered read word |
| rdata_vld | output | 1 | `rdata` holds the result of the last read |
| done | output | 1 | Access acknowledge, one cycle per access |
| err_waddr | output | 1 | Write with undefined address |
| err_wdata | output | 1 | Write with undefined data |
| err_raddr | output | 1 | Read with undefined address |

## Verification
The hardest cases to reach from the ports are address codes that fit the address bus but lie past the last word. These exist only because the default SIZE of 24 is not a power of two.

A second hard case is a reset that lands on the same edge as an access. The bench drives out-of-range addresses (24 to 31) with `addr_ok` high in both read and write forms. It also holds `acc_en` high through a reset pulse. In each case it reads the touched word back afterwards to show that nothing was stored.

// File: rtl/seqmem_pkg.sv
package seqmem_pkg;

  // Classified access for one clock edge
  typedef struct packed {
    logic act;        // an access is taken on this edge
    logic wr_go;      // write that actually stores
    logic rd_go;      // read that loads the output register
    logic bad_waddr;  // write, address undefined
    logic bad_wdata;  // write, data undefined
    logic bad_raddr;  // read, address undefined
    logic is_wr;      // any write, good or bad
  } acc_cls_t;

endpackage

// File: rtl/seqmem_decode.sv
module seqmem_decode
  import seqmem_pkg::*;
#(
  parameter int SIZE = 24,
  parameter int AW   = 5
) (
  input  logic          live_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] addr,
  input  logic          addr_ok,
  input  logic          wdata_ok,
  output acc_cls_t      cls
);

  logic in_range;

  // Range check only exists when the address bus reaches past the last word
  generate
    if (SIZE == (1 << AW)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      localparam logic [AW:0] LIMIT = SIZE[AW:0];
      assign in_range = ({1'b0, addr} < LIMIT);
    end
  endgenerate

  logic addr_def;
  assign addr_def = addr_ok & in_range;

  always_comb begin
    cls.act       = live_en;
    cls.is_wr     = live_en &  wr_sel;
    cls.bad_waddr = live_en &  wr_sel & ~addr_def;
    cls.bad_wdata = live_en &  wr_sel & ~wdata_ok;
    cls.wr_go     = live_en &  wr_sel &  addr_def & wdata_ok;
    cls.bad_raddr = live_en & ~wr_sel & ~addr_def;
    cls.rd_go     = live_en & ~wr_sel &  addr_def;
  end

endmodule

// File: rtl/seqmem_array.sv
module seqmem_array #(
  parameter int WIDTH = 16,
  parameter int SIZE  = 24,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [SIZE];
  logic [WIDTH-1:0] rd_word;
  logic [WIDTH-1:0] rdata_q;
  logic [WIDTH-1:0] rdata_nxt;

  // One enabled register per word; datapath carries no reset
  generate
    for (genvar g = 0; g < SIZE; g++) begin : g_word
      logic hit;
      assign hit = we && (addr == AW'(g));
      always_ff @(posedge clk) begin
        if (hit) mem[g] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < SIZE; i++) begin
      if (addr == AW'(i)) rd_word = mem[i];
    end
  end

  always_comb rdata_nxt = re ? rd_word : rdata_q;

  always_ff @(posedge clk) begin
    rdata_q <= rdata_nxt;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/seqmem_resp.sv
module seqmem_resp
  import seqmem_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  acc_cls_t cls,
  output logic     done,
  output logic     err_waddr,
  output logic     err_wdata,
  output logic     err_raddr,
  output logic     rdata_vld
);

  logic done_q, ew_q, ed_q, er_q, vld_q;
  logic done_n, ew_n, ed_n, er_n, vld_n;

  always_comb begin
    done_n = cls.act;
    ew_n   = cls.bad_waddr;
    ed_n   = cls.bad_wdata;
    er_n   = cls.bad_raddr;
    if (cls.rd_go)        vld_n = 1'b1;
    else if (cls.act)     vld_n = 1'b0;  // writes and failed reads
    else                  vld_n = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ew_q   <= 1'b0;
      ed_q   <= 1'b0;
      er_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      ew_q   <= ew_n;
      ed_q   <= ed_n;
      er_q   <= er_n;
      vld_q  <= vld_n;
    end
  end

  assign done      = done_q;
  assign err_waddr = ew_q;
  assign err_wdata = ed_q;
  assign err_raddr = er_q;
  assign rdata_vld = vld_q;

  // R8: read errors never coincide with write errors
  a_r8_err_kind_split: assert property (@(posedge clk) disable iff (!rst_n)
    !(er_q && (ew_q || ed_q)));

endmodule

// File: rtl/seqmem_ack.sv
module seqmem_ack
  import seqmem_pkg::*;
#(
  parameter  int WIDTH = 16,
  parameter  int SIZE  = 24,
  localparam int AW    = (SIZE > 1) ? $clog2(SIZE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             wr_sel,
  input  logic [AW-1:0]    addr,
  input  logic             addr_ok,
  input  logic [WIDTH-1:0] wdata,
  input  logic             wdata_ok,
  output logic [WIDTH-1:0] rdata,
  output logic             rdata_vld,
  output logic             done,
  output logic             err_waddr,
  output logic             err_wdata,
  output logic             err_raddr
);

  acc_cls_t cls;
  logic     live_en;

  // Reset wins over any access, including the storage write
  assign live_en = acc_en & rst_n;

  seqmem_decode #(.SIZE(SIZE), .AW(AW)) u_dec (
    .live_en  (live_en),
    .wr_sel   (wr_sel),
    .addr     (addr),
    .addr_ok  (addr_ok),
    .wdata_ok (wdata_ok),
    .cls      (cls)
  );

  seqmem_array #(.WIDTH(WIDTH), .SIZE(SIZE), .AW(AW)) u_arr (
    .clk   (clk),
    .we    (cls.wr_go),
    .re    (cls.rd_go),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  seqmem_resp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls       (cls),
    .done      (done),
    .err_waddr (err_waddr),
    .err_wdata (err_wdata),
    .err_raddr (err_raddr),
    .rdata_vld (rdata_vld)
  );

  // R4: acknowledge follows every access and nothing else
  a_r4_done_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !done);

  // R3: a write leaves the read output stale
  a_r3_write_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_sel) |=> !rdata_vld);

  // R5: idle cycles hold the read output
  a_r5_idle_hold_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(rdata_vld));
  a_r5_idle_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && rdata_vld) |=> $stable(rdata));

  // R6 / R7: a flagged write never reaches the storage
  a_r6_bad_addr_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_sel && !addr_ok) |-> !cls.wr_go);
  a_r6_bad_addr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_sel && !addr_ok) |=> err_waddr);
  a_r7_bad_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_sel && !wdata_ok) |=> (err_wdata && !$past(cls.wr_go)));

  // R8: failed read clears validity
  a_r8_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !wr_sel && !addr_ok) |=> (err_raddr && !rdata_vld));

endmodule

// File: tb/seqmem_ack_bench.sv
`timescale 1ns/1ps
module seqmem_ack_bench;

  localparam int WIDTH = 16;
  localparam int SIZE  = 24;
  localparam int AW    = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_en, wr_sel, addr_ok, wdata_ok;
  logic [AW-1:0]    addr;
  logic [WIDTH-1:0] wdata;
  logic [WIDTH-1:0] rdata;
  logic             rdata_vld, done, err_waddr, err_wdata, err_raddr;

  always #5 clk = ~clk;

  seqmem_ack #(.WIDTH(WIDTH), .SIZE(SIZE)) u_seqmem_ack (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_sel(wr_sel),
    .addr(addr), .addr_ok(addr_ok), .wdata(wdata), .wdata_ok(wdata_ok),
    .rdata(rdata), .rdata_vld(rdata_vld), .done(done),
    .err_waddr(err_waddr), .err_wdata(err_wdata), .err_raddr(err_raddr)
  );

  // Reference model state
  int               m_mem [SIZE];
  bit               m_done, m_ew, m_ed, m_er, m_vld;
  logic [WIDTH-1:0] m_rdata;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  ended = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [WIDTH-1:0] pat(int i);
    return WIDTH'(i * 16'h0713 + 16'h00a5);
  endfunction

  // Model one edge from the inputs held since the last falling edge
  task automatic model_edge();
    bit def;
    if (!rst_n) begin
      m_done = 0; m_ew = 0; m_ed = 0; m_er = 0; m_vld = 0;
    end else if (acc_en) begin
      m_done = 1;
      def = addr_ok && (int'(addr) < SIZE);
      if (wr_sel) begin
        m_ew = !def; m_ed = !wdata_ok; m_er = 0; m_vld = 0;
        if (def && wdata_ok) m_mem[int'(addr)] = int'(wdata);
      end else begin
        m_ew = 0; m_ed = 0; m_er = !def;
        if (def) begin m_rdata = WIDTH'(m_mem[int'(addr)]); m_vld = 1; end
        else m_vld = 0;
      end
    end else begin
      m_done = 0; m_ew = 0; m_ed = 0; m_er = 0;
    end
  endtask

  task automatic compare_all();
    check("R4 done", 32'(done), 32'(m_done));
    check("R6 err_waddr", 32'(err_waddr), 32'(m_ew));
    check("R7 err_wdata", 32'(err_wdata), 32'(m_ed));
    check("R8 err_raddr", 32'(err_raddr), 32'(m_er));
    check("R3 rdata_vld", 32'(rdata_vld), 32'(m_vld));
    if (m_vld) check("R2 rdata", 32'(rdata), 32'(m_rdata));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic acc(bit en, bit wr, int a, bit aok, int d, bit dok);
    acc_en = en; wr_sel = wr; addr = AW'(a); addr_ok = aok;
    wdata = WIDTH'(d); wdata_ok = dok;
    tick();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    acc_en = 0; wr_sel = 0; addr = '0; addr_ok = 0; wdata = '0; wdata_ok = 0;
    m_rdata = '0;
    for (int i = 0; i < SIZE; i++) m_mem[i] = 0;
    tick();
    tick();
    // R9: reset state
    check("R9 reset done", 32'(done), 0);
    check("R9 reset vld", 32'(rdata_vld), 0);
    check("R9 reset errs", 32'({err_waddr, err_wdata, err_raddr}), 0);
    rst_n = 1'b1;

    // R1: fill every word, then read each back
    for (int i = 0; i < SIZE; i++) acc(1, 1, i, 1, int'(pat(i)), 1);
    for (int i = SIZE - 1; i >= 0; i--) begin
      acc(1, 0, i, 1, 0, 0);
      check("R1 readback", 32'(rdata), 32'(pat(i)));
      check("R2 valid after read", 32'(rdata_vld), 1);
    end

    // R5: idle cycles keep the read result
    acc(1, 0, 3, 1, 0, 0);
    for (int k = 0; k < 4; k++) acc(0, 0, 7, 1, 0, 1);
    check("R5 idle data", 32'(rdata), 32'(pat(3)));
    check("R5 idle vld", 32'(rdata_vld), 1);

    // R3: write right after a read drops validity
    acc(1, 1, 3, 1, 16'h1234, 1);
    check("R3 stale after write", 32'(rdata_vld), 0);

    // R6: undefined address forms, storage untouched
    acc(1, 1, 2, 0, 16'hdead, 1);
    check("R6 flag addr_ok low", 32'(err_waddr), 1);
    acc(1, 1, 27, 1, 16'hbeef, 1);
    check("R6 flag out of range", 32'(err_waddr), 1);
    acc(1, 0, 2, 1, 0, 0);
    check("R6 word unchanged", 32'(rdata), 32'(pat(2)));

    // R7: undefined data, and both faults together
    acc(1, 1, 4, 1, 16'hcafe, 0);
    check("R7 flag", 32'(err_wdata), 1);
    acc(1, 1, 30, 1, 16'hf00d, 0);
    check("R7 with R6 both flags", 32'({err_waddr, err_wdata}), 32'b11);
    acc(1, 0, 4, 1, 0, 0);
    check("R7 word unchanged", 32'(rdata), 32'(pat(4)));
    acc(0, 0, 0, 0, 0, 0);
    check("R7 pulse ends", 32'(err_wdata), 0);

    // R8: read past the last word and with addr_ok low
    acc(1, 0, 25, 1, 0, 0);
    check("R8 flag range", 32'(err_raddr), 1);
    check("R8 invalid", 32'(rdata_vld), 0);
    acc(1, 0, 6, 0, 0, 0);
    check("R8 flag addr_ok low", 32'(err_raddr), 1);

    // R9: reset held over a write; word must not change
    rst_n = 1'b0;
    acc(1, 1, 5, 1, 16'h5555, 1);
    check("R9 no done in reset", 32'(done), 0);
    rst_n = 1'b1;
    acc(1, 0, 5, 1, 0, 0);
    check("R9 word survives", 32'(rdata), 32'(pat(5)));

    // Mixed traffic, compared every edge
    for (int n = 0; n < 4000; n++) begin
      acc(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
          int'($urandom_range(0, 31)), bit'($urandom_range(0, 7) != 0),
          int'($urandom_range(0, 65535)), bit'($urandom_range(0, 7) != 0));
    end

    finish_run();
  end

endmodule